// File: doc/BRIEF.md
# Low-Power Stop Broadcast Responder with Clock Gate Control

This block sits on the system side of a processor bus. It watches every transfer start for the one broadcast that a processor issues before it enters its low-power stop state. That broadcast is a write to the all-ones address with transfer type 3 and transfer modifier 0. When the block sees it, it ends the cycle with a single-clock termination strobe and keeps the 16-bit immediate operand carried on the low data lanes. It then takes charge of the bus while the processor goes to sleep.

After it accepts the broadcast, the block drives bus grant toward the processor and holds off every alternate master. It also tells the arbiter not to rely on transfer-start and tenure tracking from the processor. The hold on alternate masters is released once the processor status reads the stopped code 0x16. When that code has been seen on two clocks in a row, the block raises a clock-stop request. The clock is then gated only at an edge where the observed processor clock is low. A wake input returns everything to idle.

A configuration input makes the block answer the broadcast with retry instead of acknowledge. This lets the processor's reissue path be exercised. A malformed broadcast, meaning the all-ones address with type 3 but the wrong direction or modifier, is ended with an error.

Top module: `lpstop_responder`

## Requirements
- R1: A transfer start that is a write (`bus_write`=1) to address 0xFFFFFFFF with `bus_ttype`=3 and `bus_tmod`=0 is a broadcast. With `cfg_retry`=0 it gets `term_ack` high for exactly the one cycle that follows the edge at which the start was sampled.
- R2: At most one of `term_ack`, `term_retry` and `term_err` is high in any cycle, and each is high only in the cycle after a sampled transfer start.
- R3: With `cfg_retry`=1, a broadcast is ended with `term_retry` instead of `term_ack`. The captured value, grant, hold, override and clock-stop outputs are then left unchanged.
- R4: A start to 0xFFFFFFFF with `bus_ttype`=3 that is a read or has `bus_tmod`≠0 is ended with `term_err`. It does not start the sleep sequence.
- R5: Any other transfer start produces no termination and changes no output.
- R6: On an acknowledged broadcast, `imm_data` takes `bus_data` as sampled with the start, and `imm_valid` pulses for one cycle together with `term_ack`.
- R7: From the cycle after an acknowledged broadcast that arrives while idle, `bus_grant`, `altm_hold` and `track_ovr` are high.
- R8: `altm_hold` falls after the first edge at which `proc_status`=0x16 is sampled while asleep. `bus_grant` and `track_ovr` stay high until wake.
- R9: A clock-stop request forms only after `proc_status`=0x16 is sampled at two consecutive edges while asleep. Any other value in between restarts the count. Once formed, the request persists until wake.
- R10: `clk_stop` rises only at an edge where `clk_low`=1 and the request exists, and it stays high until wake.
- R11: `wake` high at an edge while asleep returns grant, hold, override, request and `clk_stop` to low after that edge.
- R12: During and right after reset, all outputs are low and `imm_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Transfer start strobe, one cycle |
| bus_write | input | 1 | 1 = write transfer |
| bus_addr | input | 32 | Transfer address |
| bus_ttype | input | 2 | Transfer type |
| bus_tmod | input | 3 | Transfer modifier |
| bus_data | input | 16 | Low data lanes carrying the immediate value |
| cfg_retry | input | 1 | 1 = answer broadcast with retry |
| proc_status | input | 5 | Processor status code |
| clk_low | input | 1 | Observed processor clock is in its low phase |
| wake | input | 1 | Wake request from the system |
| term_ack | output | 1 | Normal termination strobe |
| term_retry | output | 1 | Retry termination strobe |
| term_err | output | 1 | Error termination strobe |
| imm_data | output | 16 | Captured immediate value |
| imm_valid | output | 1 | One-cycle pulse when imm_data is refreshed |
| bus_grant | output | 1 | Grant driven to the processor |
| altm_hold | output | 1 | Halt all alternate-master activity |
| track_ovr | output | 1 | Arbiter must ignore start/tenure tracking |
| clk_stop | output | 1 | Gate the processor clock |

## Verification
Broadcasts are mixed with near misses that differ in one field at a time: direction, modifier, address and type. This separates the acknowledge, error and silent paths of the decode. The same broadcast is sent once with retry selected and once without, which shows that only the acknowledged form starts the sleep sequence and captures data. The status stream is broken after a single 0x16 before two clean samples arrive, and `clk_low` is held high only on chosen cycles. This tells a correct two-sample count and low-phase gating apart from a one-sample or ungated version. Wake is applied both during the hold phase and after the clock stop, and a second broadcast is sent while asleep.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

  typedef enum logic [1:0] {
    SLP_IDLE = 2'd0,
    SLP_HOLD = 2'd1,
    SLP_RUN  = 2'd2
  } slp_state_t;

  typedef enum logic [1:0] {
    TERM_NONE  = 2'd0,
    TERM_ACK   = 2'd1,
    TERM_RETRY = 2'd2,
    TERM_ERR   = 2'd3
  } term_kind_t;

endpackage

// File: rtl/lpstop_decode.sv
module lpstop_decode
  import lpstop_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int TT_W     = 2,
  parameter int TM_W     = 3,
  parameter int BCAST_TT = 3,
  parameter int BCAST_TM = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TT_W-1:0]   bus_ttype,
  input  logic [TM_W-1:0]   bus_tmod,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              cfg_retry,
  output logic              take_evt,
  output logic              term_ack,
  output logic              term_retry,
  output logic              term_err,
  output logic [DATA_W-1:0] imm_data,
  output logic              imm_valid
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam logic [TT_W-1:0]   TT_CODE  = TT_W'(BCAST_TT);
  localparam logic [TM_W-1:0]   TM_CODE  = TM_W'(BCAST_TM);

  function automatic logic sig_space(input logic [ADDR_W-1:0] a,
                                     input logic [TT_W-1:0]   tt);
    return (a == ALL_ONES) && (tt == TT_CODE);
  endfunction

  function automatic logic sig_exact(input logic                w,
                                     input logic [ADDR_W-1:0] a,
                                     input logic [TT_W-1:0]   tt,
                                     input logic [TM_W-1:0]   tm);
    return sig_space(a, tt) && w && (tm == TM_CODE);
  endfunction

  function automatic term_kind_t pick_term(input logic st,
                                           input logic exact,
                                           input logic space,
                                           input logic rty);
    if (!st)         return TERM_NONE;
    else if (exact)  return rty ? TERM_RETRY : TERM_ACK;
    else if (space)  return TERM_ERR;
    else             return TERM_NONE;
  endfunction

  logic       hit_exact;
  logic       hit_space;
  term_kind_t term_nxt;

  assign hit_exact = sig_exact(bus_write, bus_addr, bus_ttype, bus_tmod);
  assign hit_space = sig_space(bus_addr, bus_ttype);
  assign term_nxt  = pick_term(bus_start, hit_exact, hit_space, cfg_retry);
  assign take_evt  = (term_nxt == TERM_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_ack   <= 1'b0;
      term_retry <= 1'b0;
      term_err   <= 1'b0;
      imm_valid  <= 1'b0;
      imm_data   <= '0;
    end else begin
      term_ack   <= (term_nxt == TERM_ACK);
      term_retry <= (term_nxt == TERM_RETRY);
      term_err   <= (term_nxt == TERM_ERR);
      imm_valid  <= take_evt;
      if (take_evt) imm_data <= bus_data;
    end
  end

  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({term_ack, term_retry, term_err})); // R2

  AST_TERM_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ack || term_retry || term_err) |-> $past(bus_start)); // R2

  AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid |-> term_ack); // R6

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_valid && !$past(take_evt) |-> $stable(imm_data)); // R6

endmodule

// File: rtl/lpstop_sleep_ctl.sv
module lpstop_sleep_ctl
  import lpstop_pkg::*;
#(
  parameter int PST_W      = 5,
  parameter int SLEEP_CODE = 'h16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_evt,
  input  logic [PST_W-1:0] proc_status,
  input  logic             wake,
  output logic             asleep,
  output logic             bus_grant,
  output logic             altm_hold,
  output logic             track_ovr
);

  localparam logic [PST_W-1:0] STOP_PST = PST_W'(SLEEP_CODE);

  function automatic slp_state_t next_state(input slp_state_t s,
                                            input logic       tk,
                                            input logic       wk,
                                            input logic       stopped);
    case (s)
      SLP_IDLE: return tk ? SLP_HOLD : SLP_IDLE;
      SLP_HOLD: return wk ? SLP_IDLE : (stopped ? SLP_RUN : SLP_HOLD);
      SLP_RUN:  return wk ? SLP_IDLE : SLP_RUN;
      default:  return SLP_IDLE;
    endcase
  endfunction

  slp_state_t state_q;
  slp_state_t state_d;
  logic       pst_stopped;

  assign pst_stopped = (proc_status == STOP_PST);
  assign state_d     = next_state(state_q, take_evt, wake, pst_stopped);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SLP_IDLE;
    else        state_q <= state_d;
  end

  assign asleep    = (state_q != SLP_IDLE);
  assign bus_grant = asleep;
  assign track_ovr = asleep;
  assign altm_hold = (state_q == SLP_HOLD);

  AST_ENTER_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && take_evt) |=> altm_hold); // R7

  AST_HOLD_IMPLIES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    altm_hold |-> (bus_grant && track_ovr)); // R7

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (altm_hold && pst_stopped && !wake) |=> (!altm_hold && bus_grant)); // R8

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake) |=> !bus_grant); // R11

endmodule

// File: rtl/lpstop_clkstop.sv
module lpstop_clkstop #(
  parameter int PST_W      = 5,
  parameter int SLEEP_CODE = 'h16,
  parameter int STREAK_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asleep,
  input  logic [PST_W-1:0] proc_status,
  input  logic             clk_low,
  input  logic             wake,
  output logic             stop_req,
  output logic             clk_stop
);

  localparam int              CNT_W    = $clog2(STREAK_N + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STREAK_N);
  localparam logic [PST_W-1:0] STOP_PST = PST_W'(SLEEP_CODE);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c,
                                            input logic              hit);
    if (!hit)             return '0;
    else if (c == CNT_TOP) return c;
    else                  return c + 1'b1;
  endfunction

  logic [CNT_W-1:0] streak_q;
  logic [CNT_W-1:0] streak_d;
  logic             pst_hit;
  logic             clear_all;
  logic             req_form;
  logic             gate_now;

  assign pst_hit   = (proc_status == STOP_PST);
  assign clear_all = !asleep || wake;
  assign streak_d  = bump(streak_q, pst_hit);
  assign req_form  = (streak_d == CNT_TOP);
  assign gate_now  = stop_req && clk_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak_q <= '0;
      stop_req <= 1'b0;
      clk_stop <= 1'b0;
    end else if (clear_all) begin
      streak_q <= '0;
      stop_req <= 1'b0;
      clk_stop <= 1'b0;
    end else begin
      streak_q <= streak_d;
      if (req_form) stop_req <= 1'b1;
      if (gate_now) clk_stop <= 1'b1;
    end
  end

  AST_STOP_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop) |-> $past(clk_low)); // R10

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> stop_req); // R9

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && asleep && !wake) |=> stop_req); // R9

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && !wake) |=> clk_stop); // R10

endmodule

// File: rtl/lpstop_responder.sv
module lpstop_responder #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 16,
  parameter int TT_W       = 2,
  parameter int TM_W       = 3,
  parameter int PST_W      = 5,
  parameter int BCAST_TT   = 3,
  parameter int BCAST_TM   = 0,
  parameter int SLEEP_CODE = 'h16,
  parameter int STREAK_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TT_W-1:0]   bus_ttype,
  input  logic [TM_W-1:0]   bus_tmod,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              cfg_retry,
  input  logic [PST_W-1:0]  proc_status,
  input  logic              clk_low,
  input  logic              wake,
  output logic              term_ack,
  output logic              term_retry,
  output logic              term_err,
  output logic [DATA_W-1:0] imm_data,
  output logic              imm_valid,
  output logic              bus_grant,
  output logic              altm_hold,
  output logic              track_ovr,
  output logic              clk_stop
);

  logic take_evt;
  logic asleep;
  logic stop_req;

  lpstop_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TT_W(TT_W), .TM_W(TM_W),
    .BCAST_TT(BCAST_TT), .BCAST_TM(BCAST_TM)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_ttype(bus_ttype), .bus_tmod(bus_tmod), .bus_data(bus_data),
    .cfg_retry(cfg_retry),
    .take_evt(take_evt),
    .term_ack(term_ack), .term_retry(term_retry), .term_err(term_err),
    .imm_data(imm_data), .imm_valid(imm_valid)
  );

  lpstop_sleep_ctl #(
    .PST_W(PST_W), .SLEEP_CODE(SLEEP_CODE)
  ) u_slp (
    .clk(clk), .rst_n(rst_n),
    .take_evt(take_evt), .proc_status(proc_status), .wake(wake),
    .asleep(asleep), .bus_grant(bus_grant), .altm_hold(altm_hold),
    .track_ovr(track_ovr)
  );

  lpstop_clkstop #(
    .PST_W(PST_W), .SLEEP_CODE(SLEEP_CODE), .STREAK_N(STREAK_N)
  ) u_cks (
    .clk(clk), .rst_n(rst_n),
    .asleep(asleep), .proc_status(proc_status), .clk_low(clk_low),
    .wake(wake), .stop_req(stop_req), .clk_stop(clk_stop)
  );

  AST_RETRY_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (term_retry && !$past(asleep)) |-> !bus_grant); // R3

  AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (term_err && !$past(asleep)) |-> !bus_grant); // R4

  AST_STOP_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (bus_grant && !altm_hold)); // R10

endmodule

// File: tb/sim_lpstop_responder.sv
module sim_lpstop_responder;
  localparam int PERIOD = 10;
  localparam int WDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_ttype = '0;
  logic [2:0]  bus_tmod = '0;
  logic [15:0] bus_data = '0;
  logic        cfg_retry = 1'b0;
  logic [4:0]  proc_status = '0;
  logic        clk_low = 1'b0, wake = 1'b0;
  logic        term_ack, term_retry, term_err, imm_valid;
  logic        bus_grant, altm_hold, track_ovr, clk_stop;
  logic [15:0] imm_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_state = 0;   // 0 idle, 1 hold, 2 run
  int m_streak = 0;
  bit m_req = 0, m_stop = 0;
  bit m_ack = 0, m_rty = 0, m_err = 0, m_vld = 0;
  int m_imm = 0;

  always #(PERIOD/2) clk = ~clk;

  lpstop_responder u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_ttype(bus_ttype), .bus_tmod(bus_tmod),
    .bus_data(bus_data), .cfg_retry(cfg_retry), .proc_status(proc_status),
    .clk_low(clk_low), .wake(wake), .term_ack(term_ack),
    .term_retry(term_retry), .term_err(term_err), .imm_data(imm_data),
    .imm_valid(imm_valid), .bus_grant(bus_grant), .altm_hold(altm_hold),
    .track_ovr(track_ovr), .clk_stop(clk_stop)
  );

  always @(posedge clk) begin
    bit exact, space, asl, hit16;
    if (!rst_n) begin
      m_state = 0; m_streak = 0; m_req = 0; m_stop = 0;
      m_ack = 0; m_rty = 0; m_err = 0; m_vld = 0; m_imm = 0;
    end else begin
      space = (bus_addr == 32'hFFFF_FFFF) && (bus_ttype == 2'd3);
      exact = space && bus_write && (bus_tmod == 3'd0);
      m_ack = bus_start && exact && !cfg_retry;
      m_rty = bus_start && exact && cfg_retry;
      m_err = bus_start && space && !exact;
      m_vld = m_ack;
      if (m_ack) m_imm = bus_data;
      asl   = (m_state != 0);
      hit16 = (proc_status == 5'h16);
      if (!asl || wake) begin
        m_streak = 0; m_req = 0; m_stop = 0;
      end else begin
        if (m_req && clk_low) m_stop = 1;
        if (hit16) m_streak = (m_streak < 2) ? m_streak + 1 : 2;
        else       m_streak = 0;
        if (m_streak == 2) m_req = 1;
      end
      if (m_state == 0)      m_state = m_ack ? 1 : 0;
      else if (wake)         m_state = 0;
      else if (m_state == 1 && hit16) m_state = 2;
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "term_ack",   int'(term_ack),   int'(m_ack));
    chk("R3", "term_retry", int'(term_retry), int'(m_rty));
    chk("R4", "term_err",   int'(term_err),   int'(m_err));
    chk("R2", "term_onehot", int'($countones({term_ack, term_retry, term_err}) <= 1), 1);
    chk("R6", "imm_valid",  int'(imm_valid),  int'(m_vld));
    chk("R6", "imm_data",   int'(imm_data),   m_imm);
    chk("R7", "bus_grant",  int'(bus_grant),  int'(m_state != 0));
    chk("R7", "track_ovr",  int'(track_ovr),  int'(m_state != 0));
    chk("R8", "altm_hold",  int'(altm_hold),  int'(m_state == 1));
    chk("R10", "clk_stop",  int'(clk_stop),   int'(m_stop));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      bus_start = 1'b0;
    end
  endtask

  task automatic xfer(input bit w, input logic [31:0] a, input logic [1:0] tt,
                      input logic [2:0] tm, input logic [15:0] d);
    bus_start = 1'b1; bus_write = w; bus_addr = a;
    bus_ttype = tt; bus_tmod = tm; bus_data = d;
    step(1);
    step(2);
  endtask

  initial begin
    // R12: reset state
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R12", "reset_outputs",
        int'({term_ack, term_retry, term_err, imm_valid, bus_grant,
              altm_hold, track_ovr, clk_stop} == 8'd0 && imm_data == 16'd0), 1);

    // R5: near misses that must stay silent
    xfer(1, 32'hFFFF_FFFE, 2'd3, 3'd0, 16'h1111);
    xfer(1, 32'hFFFF_FFFF, 2'd1, 3'd0, 16'h2222);
    xfer(1, 32'h0000_1000, 2'd0, 3'd0, 16'h3333);
    // R4: malformed broadcast forms
    xfer(0, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'h4444);
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd5, 16'h5555);
    // R3: retry configured
    cfg_retry = 1'b1;
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'h6666);
    cfg_retry = 1'b0;
    // R1 R6 R7: accepted broadcast
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'hBEEF);
    // R8 R9: broken status streak, then clean pair
    proc_status = 5'h16; step(1);
    proc_status = 5'h03; step(1);
    proc_status = 5'h16; step(1);
    proc_status = 5'h16; step(1);
    // R10: request present but clock high, then low
    clk_low = 1'b0; step(3);
    clk_low = 1'b1; step(1);
    clk_low = 1'b0; step(2);
    // broadcast while asleep keeps state
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'hCAFE);
    // R11: wake after clock stop
    wake = 1'b1; step(1);
    wake = 1'b0; step(2);
    // second sleep, wake during hold phase
    proc_status = 5'h00;
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'h0A5A);
    wake = 1'b1; step(1);
    wake = 1'b0; step(2);
    // third sleep: single-sample status must not gate clock (R9)
    xfer(1, 32'hFFFF_FFFF, 2'd3, 3'd0, 16'h7F01);
    clk_low = 1'b1;
    proc_status = 5'h16; step(1);
    proc_status = 5'h00; step(3);
    proc_status = 5'h16; step(4);
    wake = 1'b1; step(1);
    wake = 1'b0; clk_low = 1'b0; step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule